// File: doc/BRIEF.md
# Sector Lockout and Write Protection Guard

This block sits beside the command decoder of a sectored non-volatile memory. Each sector owns a lockout bit that a lock command can set but no command can clear. Every erase or program request arrives as a one-cycle pulse that carries a sector index. The guard answers it one cycle later with either a grant or a deny. A request aimed at a locked sector is refused unless the high-voltage override flag is raised. That refusal also holds a busy indication for a fixed abort window, and commands that arrive during that window are dropped. The data array itself never sees a refused request.

A second path qualifies the raw bus strobes. A write is recognised only when both enables are active, output-enable is inactive, and the strobe stays active for a minimum number of clock samples. The supply-good flag must be high and its power-on hold-off must have elapsed. While the guard is in identification mode, a read at a fixed word offset inside a sector returns that sector's lockout bit. Supply detection and high-voltage detection happen outside this block and reach it as synchronous digital flags.

Top module: `sector_guard`

## Requirements
- R1: After reset all lockout bits are clear, `grant`, `deny`, `reject_busy`, `wr_strobe_ok` and `id_data` are 0, and `prog_inhibit` is 1.
- R2: Operation codes are 0 = erase, 1 = program, 2 = lock and 3 = reserved. An erase or program sampled with `cmd_valid` to an in-range, unlocked sector while not inhibited drives `grant` high for exactly the next cycle, and `deny` stays low.
- R3: An erase or program to a locked sector with `hv_override` low drives `deny` for one cycle and no grant. `reject_busy` is high for exactly ABORT_CYC cycles, starting in the cycle in which `deny` is high.
- R4: With `hv_override` high, an erase or program to a locked sector is granted. Once the flag is low again, the same request is refused as in R3.
- R5: A granted lock command (code 2) sets the addressed sector's bit, and the bit then stays set. No command clears it; only reset does.
- R6: With `id_mode` high and `rd_offset` equal to 2, `id_data` shows the lockout bit of `rd_sector` on bit 0 (1 = locked), one cycle after the inputs are applied. Any other offset, an out-of-range sector, or `id_mode` low gives 0.
- R7: A command presented while `reject_busy` is high is ignored: it produces neither grant nor deny.
- R8: `prog_inhibit` is high while `vcc_ok` is low and for PWR_HOLD_CYC clock edges after `vcc_ok` rises. Any command accepted while inhibited is denied without `reject_busy`.
- R9: `wr_strobe_ok` pulses for one cycle, one cycle after a write strobe ends, if the strobe lasted at least GLITCH_MIN clock samples. A write strobe means write-enable low, chip-enable low and output-enable high. Shorter strobes give no pulse.
- R10: A strobe that ends because output-enable went low gives no pulse. A strobe that ends while `prog_inhibit` is high also gives no pulse.
- R11: A sector index of NUM_SECTORS or more, or operation code 3, is denied without `reject_busy` and changes no lockout bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lockout state |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_op | input | 2 | Operation code (0 erase, 1 program, 2 lock, 3 reserved) |
| cmd_sector | input | SEC_W | Target sector index |
| hv_override | input | 1 | High-voltage override present |
| vcc_ok | input | 1 | Supply above the sense level |
| we_n | input | 1 | Raw write-enable strobe, active low |
| ce_n | input | 1 | Raw chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable, active low |
| id_mode | input | 1 | Identification read mode |
| rd_sector | input | SEC_W | Sector of the identification read |
| rd_offset | input | OFF_W | Word offset within the sector |
| grant | output | 1 | Request may proceed |
| deny | output | 1 | Request refused |
| reject_busy | output | 1 | Abort window of a refused protected request |
| prog_inhibit | output | 1 | Programming blocked by supply or hold-off |
| wr_strobe_ok | output | 1 | Qualified write strobe completed |
| id_data | output | DATA_W | Identification read data |

## Verification
The checker watches several properties on every cycle. A verdict is never both grant and deny. A busy window opens only with a deny and never runs longer than the abort length. No verdict follows a command that arrived during a busy window. Lockout bits only ever get set. A supply rise is always followed by inhibit. A qualified strobe pulse needs power and output-enable high in the cycle before, and it lasts one cycle.

Only the bench scenarios can show the following. The exact verdict for each combination of sector, code and override. The exact length of the abort window and of the power-on hold-off. The glitch threshold at exactly GLITCH_MIN versus one sample less. The identification readback of particular sectors. That reset really clears the lockouts.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      OP_ERASE = 2'd0,
      OP_PROG  = 2'd1,
      OP_LOCK  = 2'd2,
      OP_RSVD  = 2'd3
   } sg_op_e;

   typedef enum logic [1:0] {
      V_NONE  = 2'd0,
      V_GRANT = 2'd1,
      V_DENY  = 2'd2,
      V_ABORT = 2'd3
   } sg_verdict_e;
endpackage

// File: rtl/sg_lock_store.sv
module sg_lock_store #(
   parameter int NUM_SECTORS = 40,
   parameter int SEC_W       = 6,
   parameter int OFF_W       = 4,
   parameter int DATA_W      = 8,
   parameter int LOCK_OFF    = 2,
   parameter int ID_REG      = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [SEC_W-1:0]       set_sel,
   input  logic                   id_mode,
   input  logic [SEC_W-1:0]       rd_sector,
   input  logic [OFF_W-1:0]       rd_offset,
   output logic [NUM_SECTORS-1:0] lock_vec,
   output logic [DATA_W-1:0]      id_data
);
   logic [NUM_SECTORS-1:0] lock_q;
   logic                   rd_in_range;
   logic                   id_hit;
   logic [DATA_W-1:0]      id_word;

   // one set-only flop per sector
   for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lock_q[i] <= 1'b0;
         else if (set_en && (set_sel == SEC_W'(i)))
            lock_q[i] <= 1'b1;
      end
   end

   assign lock_vec    = lock_q;
   assign rd_in_range = ({1'b0, rd_sector} < (SEC_W+1)'(NUM_SECTORS));
   assign id_hit      = id_mode && (rd_offset == OFF_W'(LOCK_OFF)) && rd_in_range;
   assign id_word     = DATA_W'(id_hit && lock_q[rd_sector]);

   if (ID_REG != 0) begin : g_id_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) id_data <= '0;
         else        id_data <= id_word;
      end
   end else begin : g_id_comb
      assign id_data = id_word;
   end
endmodule

// File: rtl/sg_abort_timer.sv
module sg_abort_timer #(
   parameter int ABORT_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(ABORT_CYC + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= CW'(ABORT_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/sg_write_qual.sv
module sg_write_qual #(
   parameter int PWR_HOLD_CYC = 2500000,
   parameter int GLITCH_MIN   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_ok,
   input  logic we_n,
   input  logic ce_n,
   input  logic oe_n,
   output logic prog_inhibit,
   output logic strobe_ok
);
   localparam int PW = $clog2(PWR_HOLD_CYC + 1);
   localparam int GW = $clog2(GLITCH_MIN + 1);

   logic [PW-1:0] pwr_cnt_q;
   logic [GW-1:0] low_cnt_q;
   logic          act_now;
   logic          act_q;
   logic          long_enough;
   logic          clean_end;

   // power-on hold-off: reloads whenever the supply is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pwr_cnt_q <= PW'(PWR_HOLD_CYC);
      else if (!vcc_ok)
         pwr_cnt_q <= PW'(PWR_HOLD_CYC);
      else if (pwr_cnt_q != '0)
         pwr_cnt_q <= pwr_cnt_q - 1'b1;
   end

   assign prog_inhibit = !vcc_ok || (pwr_cnt_q != '0);

   // strobe width measured in clock samples, saturating
   assign act_now = !we_n && !ce_n && oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
         act_q     <= 1'b0;
      end else begin
         act_q <= act_now;
         if (!act_now)
            low_cnt_q <= '0;
         else if (low_cnt_q != GW'(GLITCH_MIN))
            low_cnt_q <= low_cnt_q + 1'b1;
      end
   end

   assign long_enough = (low_cnt_q == GW'(GLITCH_MIN));
   assign clean_end   = act_q && !act_now && oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_ok <= 1'b0;
      else        strobe_ok <= clean_end && long_enough && !prog_inhibit;
   end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
   parameter int NUM_SECTORS  = 40,
   parameter int ABORT_CYC    = 500,
   parameter int PWR_HOLD_CYC = 2500000,
   parameter int GLITCH_MIN   = 4,
   parameter int OFF_W        = 4,
   parameter int LOCK_OFF     = 2,
   parameter int DATA_W       = 8,
   parameter int ID_REG       = 1,
   localparam int SEC_W       = $clog2(NUM_SECTORS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [SEC_W-1:0]  cmd_sector,
   input  logic              hv_override,
   input  logic              vcc_ok,
   input  logic              we_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              id_mode,
   input  logic [SEC_W-1:0]  rd_sector,
   input  logic [OFF_W-1:0]  rd_offset,
   output logic              grant,
   output logic              deny,
   output logic              reject_busy,
   output logic              prog_inhibit,
   output logic              wr_strobe_ok,
   output logic [DATA_W-1:0] id_data
);
   import sg_pkg::*;

   if (NUM_SECTORS < 2)              begin : g_bad_n   $error("NUM_SECTORS must be at least 2"); end
   if (ABORT_CYC < 1)                begin : g_bad_a   $error("ABORT_CYC must be at least 1"); end
   if (PWR_HOLD_CYC < 2)             begin : g_bad_p   $error("PWR_HOLD_CYC must be at least 2"); end
   if (GLITCH_MIN < 1)               begin : g_bad_g   $error("GLITCH_MIN must be at least 1"); end
   if (LOCK_OFF >= (1 << OFF_W))     begin : g_bad_o   $error("LOCK_OFF does not fit OFF_W"); end
   if (DATA_W < 1)                   begin : g_bad_d   $error("DATA_W must be at least 1"); end
   if (ID_REG < 0 || ID_REG > 1)     begin : g_bad_r   $error("ID_REG must be 0 or 1"); end

   sg_op_e                 op;
   sg_verdict_e            verdict;
   logic [NUM_SECTORS-1:0] lock_vec;
   logic                   take;
   logic                   in_range;
   logic                   tgt_locked;
   logic                   set_en;
   logic                   grant_q;
   logic                   deny_q;

   assign op         = sg_op_e'(cmd_op);
   assign take       = cmd_valid && !reject_busy;
   assign in_range   = ({1'b0, cmd_sector} < (SEC_W+1)'(NUM_SECTORS));
   assign tgt_locked = in_range && lock_vec[cmd_sector];

   always_comb begin
      if (!take)
         verdict = V_NONE;
      else if (!in_range || prog_inhibit || op == OP_RSVD)
         verdict = V_DENY;
      else if (op == OP_LOCK)
         verdict = V_GRANT;
      else if (tgt_locked && !hv_override)
         verdict = V_ABORT;
      else
         verdict = V_GRANT;
   end

   assign set_en = (verdict == V_GRANT) && (op == OP_LOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
      end else begin
         grant_q <= (verdict == V_GRANT);
         deny_q  <= (verdict == V_DENY) || (verdict == V_ABORT);
      end
   end

   assign grant = grant_q;
   assign deny  = deny_q;

   sg_lock_store #(
      .NUM_SECTORS (NUM_SECTORS),
      .SEC_W       (SEC_W),
      .OFF_W       (OFF_W),
      .DATA_W      (DATA_W),
      .LOCK_OFF    (LOCK_OFF),
      .ID_REG      (ID_REG)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .set_sel   (cmd_sector),
      .id_mode   (id_mode),
      .rd_sector (rd_sector),
      .rd_offset (rd_offset),
      .lock_vec  (lock_vec),
      .id_data   (id_data)
   );

   sg_abort_timer #(
      .ABORT_CYC (ABORT_CYC)
   ) i_abort (
      .clk   (clk),
      .rst_n (rst_n),
      .start (verdict == V_ABORT),
      .busy  (reject_busy)
   );

   sg_write_qual #(
      .PWR_HOLD_CYC (PWR_HOLD_CYC),
      .GLITCH_MIN   (GLITCH_MIN)
   ) i_wq (
      .clk          (clk),
      .rst_n        (rst_n),
      .vcc_ok       (vcc_ok),
      .we_n         (we_n),
      .ce_n         (ce_n),
      .oe_n         (oe_n),
      .prog_inhibit (prog_inhibit),
      .strobe_ok    (wr_strobe_ok)
   );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int NUM_SECTORS = 40,
   parameter int ABORT_CYC   = 500
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   grant,
   input logic                   deny,
   input logic                   reject_busy,
   input logic                   vcc_ok,
   input logic                   oe_n,
   input logic                   prog_inhibit,
   input logic                   wr_strobe_ok,
   input logic [NUM_SECTORS-1:0] lock_vec
);
   localparam int RW = $clog2(ABORT_CYC + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= '0;
      else if (reject_busy) run_q <= run_q + 1'b1;
      else                  run_q <= '0;
   end

   a_r2_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && deny));

   a_r3_busy_opens_with_deny: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reject_busy) |-> deny);

   a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      reject_busy |-> (run_q < RW'(ABORT_CYC)));

   a_r7_no_verdict_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (grant || deny) |-> !$past(reject_busy));

   a_r5_lock_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(lock_vec) & ~lock_vec) == '0));

   a_r8_inhibit_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vcc_ok) |=> prog_inhibit);

   a_r9_strobe_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_ok |-> !$past(prog_inhibit));

   a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_ok |=> !wr_strobe_ok);

   a_r10_strobe_needs_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_ok |-> $past(oe_n));
endmodule

bind sector_guard sg_checker #(
   .NUM_SECTORS (NUM_SECTORS),
   .ABORT_CYC   (ABORT_CYC)
) i_sg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .grant        (grant),
   .deny         (deny),
   .reject_busy  (reject_busy),
   .vcc_ok       (vcc_ok),
   .oe_n         (oe_n),
   .prog_inhibit (prog_inhibit),
   .wr_strobe_ok (wr_strobe_ok),
   .lock_vec     (lock_vec)
);

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
   localparam int N_SEC  = 40;
   localparam int ABORT  = 25;
   localparam int HOLD   = 40;
   localparam int GMIN   = 4;

   typedef struct packed {
      logic [1:0] op;
      logic [5:0] sec;
      logic       ov;
      logic       eg;
      logic       ed;
      logic       eb;
   } vec_t;

   // op, sector, override, expect grant, expect deny, expect busy
   localparam vec_t VECS [17] = '{
      '{2'd0, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd2, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 6'd5,  1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd1, 6'd5,  1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd0, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0},
      '{2'd1, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0},
      '{2'd0, 6'd5,  1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd2, 6'd39, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd1, 6'd39, 1'b0, 1'b0, 1'b1, 1'b1},
      '{2'd1, 6'd38, 1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd0, 6'd40, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd2, 6'd63, 1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd3, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0},
      '{2'd1, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd2, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0},
      '{2'd2, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0},
      '{2'd1, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic [5:0] cmd_sector = '0;
   logic       hv_override = 1'b0;
   logic       vcc_ok = 1'b0;
   logic       we_n = 1'b1;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic       id_mode = 1'b0;
   logic [5:0] rd_sector = '0;
   logic [3:0] rd_offset = '0;
   logic       grant, deny, reject_busy, prog_inhibit, wr_strobe_ok;
   logic [7:0] id_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   sector_guard #(
      .NUM_SECTORS  (N_SEC),
      .ABORT_CYC    (ABORT),
      .PWR_HOLD_CYC (HOLD),
      .GLITCH_MIN   (GMIN)
   ) i_sector_guard (
      .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_sector, .hv_override, .vcc_ok,
      .we_n, .ce_n, .oe_n, .id_mode, .rd_sector, .rd_offset,
      .grant, .deny, .reject_busy, .prog_inhibit, .wr_strobe_ok, .id_data
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // issue one command; leaves time at the negedge where the verdict is visible
   task automatic issue(input logic [1:0] op, input logic [5:0] sec, input logic ov);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec; hv_override = ov;
      @(negedge clk);
      cmd_valid = 1'b0; hv_override = 1'b0;
   endtask

   task automatic busy_len(output int len);
      len = 0;
      while (reject_busy && len < 1000) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic strobe(input int width, input bit end_by_oe, output int pulses);
      @(negedge clk);
      we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1;
      repeat (width) @(negedge clk);
      if (end_by_oe) oe_n = 1'b0;
      else           we_n = 1'b1;
      pulses = 0;
      repeat (3) begin
         @(negedge clk);
         if (wr_strobe_ok) pulses++;
      end
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic id_read(input string req, input logic mode, input logic [5:0] sec,
                          input logic [3:0] off, input int exp);
      @(negedge clk);
      id_mode = mode; rd_sector = sec; rd_offset = off;
      @(negedge clk);
      chk(req, int'(id_data), exp);
      id_mode = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int len;
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 grant", grant, 0);
      chk("R1 deny", deny, 0);
      chk("R1 reject_busy", reject_busy, 0);
      chk("R1 wr_strobe_ok", wr_strobe_ok, 0);
      chk("R1 prog_inhibit", prog_inhibit, 1);
      chk("R1 id_data", int'(id_data), 0);

      // R8 command while supply is down: plain deny, no busy
      issue(2'd0, 6'd1, 1'b0);
      chk("R8 deny when inhibited", deny, 1);
      chk("R8 no grant when inhibited", grant, 0);
      chk("R8 no busy when inhibited", reject_busy, 0);

      // R10 long strobe while inhibited
      strobe(8, 1'b0, p);
      chk("R10 strobe while inhibited", p, 0);

      // R8 power-on hold-off length
      @(negedge clk);
      vcc_ok = 1'b1;
      repeat (HOLD - 1) @(negedge clk);
      chk("R8 inhibit one edge before end", prog_inhibit, 1);
      @(negedge clk);
      chk("R8 inhibit released", prog_inhibit, 0);

      // R9 / R10 strobe qualification
      strobe(GMIN, 1'b0, p);
      chk("R9 strobe at minimum width", p, 1);
      strobe(GMIN - 1, 1'b0, p);
      chk("R9 strobe one sample short", p, 0);
      strobe(GMIN + 4, 1'b0, p);
      chk("R9 long strobe", p, 1);
      strobe(GMIN + 4, 1'b1, p);
      chk("R10 strobe ended by output enable", p, 0);

      // vector table: R2 R3 R4 R5 R11
      foreach (VECS[i]) begin
         string req;
         req = VECS[i].ov ? "R4" : VECS[i].eg ? "R2" : VECS[i].eb ? "R3" : "R11";
         issue(VECS[i].op, VECS[i].sec, VECS[i].ov);
         chk($sformatf("%s vec%0d grant", req, i), grant, int'(VECS[i].eg));
         chk($sformatf("%s vec%0d deny", req, i), deny, int'(VECS[i].ed));
         busy_len(len);
         chk($sformatf("%s vec%0d busy length", req, i), len, VECS[i].eb ? ABORT : 0);
      end

      // R7 command during abort window is dropped
      issue(2'd1, 6'd5, 1'b0);
      chk("R7 setup deny", deny, 1);
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_sector = 6'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R7 no grant during abort", grant, 0);
      chk("R7 no deny during abort", deny, 0);
      busy_len(len);
      issue(2'd0, 6'd1, 1'b0);
      chk("R7 accepted after abort", grant, 1);

      // R6 identification readback
      id_read("R6 sector 5 locked", 1'b1, 6'd5, 4'd2, 1);
      id_read("R6 sector 0 locked", 1'b1, 6'd0, 4'd2, 1);
      id_read("R6 sector 39 locked", 1'b1, 6'd39, 4'd2, 1);
      id_read("R6 sector 38 free", 1'b1, 6'd38, 4'd2, 0);
      id_read("R6 out of range", 1'b1, 6'd40, 4'd2, 0);
      id_read("R6 wrong offset", 1'b1, 6'd5, 4'd1, 0);
      id_read("R6 not in id mode", 1'b0, 6'd5, 4'd2, 0);
      id_read("R11 sector 1 not locked by bad commands", 1'b1, 6'd1, 4'd2, 0);

      // R5 only reset clears lockouts
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 inhibit after reset", prog_inhibit, 1);
      id_read("R5 reset clears sector 5", 1'b1, 6'd5, 4'd2, 0);
      id_read("R5 reset clears sector 39", 1'b1, 6'd39, 4'd2, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule